// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block produces the address phase of a NAND flash command. A controller pulses `start_i` together with a description of the access: whether a column address is needed, whether a page (row) address is needed, the page address itself, whether the device uses large pages, and a code for the device capacity. The block then turns that description into an ordered series of address bytes. It hands the bytes one at a time to a downstream address-cycle issuer and flags the final byte.

Because the controller always moves whole pages, every column byte is zero. Only the number of column bytes changes with the page size. The number of row bytes depends on the page size and the capacity together, so two devices with the same page size can need different address phases.

Each byte is offered with `addr_vld_o` and held until the issuer answers with `addr_done_i`. After the final byte has been accepted, `done_o` pulses for one clock.

Top module: `nand_addr_seq`

## Requirements
- R1: When `col_vld_i` is set, the sequence begins with column bytes of value 0x00: one byte for a small-page device (`large_page_i`=0) and two bytes for a large-page device.
- R2: When `page_vld_i` is set, row bytes follow any column bytes, lowest first: page address bits 7:0, then 15:8, then (when a third row byte applies) 23:16.
- R3: `cap_sel_i` encodes capacity as 16 MiB shifted left by its value (0 = 16 MiB … 7 = 2 GiB). A large-page device uses three row bytes when `cap_sel_i` >= 4 (at least 256 MiB), otherwise two.
- R4: A small-page device uses three row bytes when `cap_sel_i` >= 2 (at least 64 MiB), otherwise two.
- R5: `addr_last_o` is high exactly while the final byte of the sequence is presented. With only the column requested, the final column byte is the last byte.
- R6: A start with neither `col_vld_i` nor `page_vld_i` emits no byte, and `done_o` is high in the cycle right after the start edge.
- R7: A byte is presented with `addr_vld_o` high and is held, together with `addr_last_o`, until `addr_done_i` is sampled high. The next byte is presented in the following cycle.
- R8: `done_o` is high for exactly one cycle, in the cycle after the edge that accepts the last byte, and `addr_vld_o` is low in that cycle.
- R9: While a sequence runs (`busy_o` high), `start_i` and a change of the request inputs have no effect. While idle, `addr_done_i` has no effect.
- R10: After a synchronous active-low reset, `addr_vld_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| col_vld_i | input | 1 | Column address requested |
| page_vld_i | input | 1 | Page address requested |
| large_page_i | input | 1 | 1 = large-page device, 0 = 512-byte page device |
| cap_sel_i | input | CAP_W (3) | Capacity code, 16 MiB << value |
| page_addr_i | input | ROW_W (24) | Page (row) address |
| addr_done_i | input | 1 | Issuer has taken the presented byte |
| addr_vld_o | output | 1 | An address byte is presented |
| addr_byte_o | output | 8 | Address byte value |
| addr_last_o | output | 1 | Presented byte is the final one |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge. A start request can arrive while a byte handshake is completing, and an `addr_done_i` can arrive while the block is idle. The bench provokes the first by holding `start_i` high, with altered request inputs, for several cycles after a sequence has been accepted. It provokes the second with an issuer that raises `addr_done_i` at random regardless of state. A behavioural queue model predicts `addr_vld_o`, `busy_o`, `done_o`, the byte and the last flag for every cycle, and the DUT is compared with it on each clock. In both cases the model's rule is that only an idle start or a busy handshake changes state.

// File: rtl/nand_addr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the NAND address cycle sequencer.
package nand_addr_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] addr_byte_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/nand_addr_plan.sv
`timescale 1ns/1ps
// Works out how many column and row bytes a request needs.
// Assumes: ROW_BYTES >= 2; the third row byte is the only capacity-dependent one.
module nand_addr_plan #(
    parameter int CAP_W          = 3,
    parameter int ROW_BYTES      = 3,
    parameter int CNT_W          = 3,
    parameter int SMALL_WIDE_MIN = 2,
    parameter int LARGE_WIDE_MIN = 4
) (
    input  logic             col_vld_i,
    input  logic             page_vld_i,
    input  logic             large_i,
    input  logic [CAP_W-1:0] cap_i,
    output logic [CNT_W-1:0] n_col_o,
    output logic [CNT_W-1:0] total_o
);
    logic [CAP_W-1:0] wide_thr;
    logic             wide;
    logic [CNT_W-1:0] n_row;

    // Capacity threshold for an extra row byte depends on page size.
    always_comb begin
        wide_thr = large_i ? CAP_W'(LARGE_WIDE_MIN) : CAP_W'(SMALL_WIDE_MIN);
        wide     = (cap_i >= wide_thr);
    end

    // Column count: two bytes on large pages, one on small pages.
    always_comb begin
        n_col_o = '0;
        if (col_vld_i) n_col_o = large_i ? CNT_W'(2) : CNT_W'(1);
    end

    // Row count: full width on dense parts, one less otherwise.
    always_comb begin
        n_row = '0;
        if (page_vld_i) n_row = wide ? CNT_W'(ROW_BYTES) : CNT_W'(ROW_BYTES - 1);
        total_o = n_col_o + n_row;
    end
endmodule

// File: rtl/nand_addr_mux.sv
`timescale 1ns/1ps
// Selects the address byte for the current sequence index.
// Assumes: indices below n_col_i are column bytes (always zero), the rest
// walk the row address from the least significant byte upward.
module nand_addr_mux
    import nand_addr_pkg::*;
#(
    parameter int ROW_W = 24,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] idx_i,
    input  logic [CNT_W-1:0] n_col_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [ROW_W-1:0] row_i,
    output addr_byte_t       byte_o,
    output logic             last_o
);
    localparam int ROW_BYTES = ROW_W / BYTE_W;

    addr_byte_t       row_b [ROW_BYTES];
    logic [CNT_W-1:0] ridx;

    // Slice the row address into bytes.
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row_slice
        assign row_b[g] = row_i[g*BYTE_W +: BYTE_W];
    end

    // Pick zero for column slots, else the row byte for this position.
    always_comb begin
        byte_o = '0;
        ridx   = idx_i - n_col_i;
        if (idx_i >= n_col_i) begin
            for (int g = 0; g < ROW_BYTES; g++) begin
                if (ridx == CNT_W'(g)) byte_o = row_b[g];
            end
        end
    end

    // Final slot of the sequence.
    assign last_o = (idx_i == total_i - CNT_W'(1));
endmodule

// File: rtl/nand_addr_ctrl.sv
`timescale 1ns/1ps
// Sequencing FSM: accepts a start while idle, steps the byte index on each
// issuer handshake and raises a one-cycle done pulse at the end.
// Assumes: total/last inputs are stable while running (driven from captured state).
module nand_addr_ctrl
    import nand_addr_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             empty_i,
    input  logic             last_i,
    input  logic             addr_done_i,
    output logic             run_o,
    output logic             load_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             done_o
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] idx_q;
    logic             done_q;

    assign run_o  = (state_q == ST_RUN);
    assign load_o = (state_q == ST_IDLE) && start_i;
    assign idx_o  = idx_q;
    assign done_o = done_q;

    // State, index and done pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        idx_q <= '0;
                        if (empty_i) done_q  <= 1'b1;
                        else         state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (addr_done_i) begin
                        if (last_i) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: a byte without handshake stays in place.
    a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !addr_done_i) |=> (run_o && $stable(idx_q)));

    // R8: done is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R6: an empty request completes at once with no cycles.
    a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && start_i && empty_i) |=> (done_q && !run_o));

    // R9: a start during a running sequence does not restart it.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && start_i && !addr_done_i) |=> (run_o && $stable(idx_q)));
endmodule

// File: rtl/nand_addr_seq.sv
`timescale 1ns/1ps
// NAND address cycle sequencer top. Captures a request on start and emits
// its column and row address bytes over a valid/done handshake.
// Assumes: the issuer only asserts addr_done_i in response to addr_vld_o.
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int ROW_W          = 24,
    parameter int CAP_W          = 3,
    parameter int SMALL_WIDE_MIN = 2,
    parameter int LARGE_WIDE_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             col_vld_i,
    input  logic             page_vld_i,
    input  logic             large_page_i,
    input  logic [CAP_W-1:0] cap_sel_i,
    input  logic [ROW_W-1:0] page_addr_i,
    input  logic             addr_done_i,
    output logic             addr_vld_o,
    output logic [7:0]       addr_byte_o,
    output logic             addr_last_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int ROW_BYTES = ROW_W / BYTE_W;
    localparam int MAX_BYTES = 2 + ROW_BYTES;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    logic             col_q, page_q, large_q;
    logic [CAP_W-1:0] cap_q;
    logic [ROW_W-1:0] row_q;
    logic             load, run, last;
    logic [CNT_W-1:0] idx, n_col, total;
    addr_byte_t       byte_sel;

    // Capture the request when the sequencer accepts a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= 1'b0;
            page_q  <= 1'b0;
            large_q <= 1'b0;
            cap_q   <= '0;
            row_q   <= '0;
        end else if (load) begin
            col_q   <= col_vld_i;
            page_q  <= page_vld_i;
            large_q <= large_page_i;
            cap_q   <= cap_sel_i;
            row_q   <= page_addr_i;
        end
    end

    nand_addr_plan #(
        .CAP_W(CAP_W), .ROW_BYTES(ROW_BYTES), .CNT_W(CNT_W),
        .SMALL_WIDE_MIN(SMALL_WIDE_MIN), .LARGE_WIDE_MIN(LARGE_WIDE_MIN)
    ) u_plan (
        .col_vld_i (col_q),
        .page_vld_i(page_q),
        .large_i   (large_q),
        .cap_i     (cap_q),
        .n_col_o   (n_col),
        .total_o   (total)
    );

    nand_addr_mux #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_mux (
        .idx_i  (idx),
        .n_col_i(n_col),
        .total_i(total),
        .row_i  (row_q),
        .byte_o (byte_sel),
        .last_o (last)
    );

    nand_addr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .empty_i    (!col_vld_i && !page_vld_i),
        .last_i     (last),
        .addr_done_i(addr_done_i),
        .run_o      (run),
        .load_o     (load),
        .idx_o      (idx),
        .done_o     (done_o)
    );

    assign addr_vld_o  = run;
    assign addr_byte_o = byte_sel;
    assign addr_last_o = run && last;
    assign busy_o      = run;

    // R5/R8: accepting the last byte ends the sequence with a done pulse.
    a_r5_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && addr_last_o && addr_done_i) |=> (done_o && !addr_vld_o));

    // R1: the first byte of a column-bearing request is zero.
    a_r1_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && col_q && idx == '0) |-> (addr_byte_o == 8'h00));

    // R7: byte and last flag are held while the issuer has not answered.
    a_r7_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && !addr_done_i) |=> ($stable(addr_byte_o) && $stable(addr_last_o)));
endmodule

// File: tb/tb_nand_addr_seq.sv
`timescale 1ns/1ps
module tb_nand_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        col_vld_i = 1'b0;
    logic        page_vld_i = 1'b0;
    logic        large_page_i = 1'b0;
    logic [2:0]  cap_sel_i = '0;
    logic [23:0] page_addr_i = '0;
    logic        addr_done_i = 1'b0;
    logic        addr_vld_o, addr_last_o, busy_o, done_o;
    logic [7:0]  addr_byte_o;

    int chk_cnt = 0;
    int fail_cnt = 0;
    int hs_cnt = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;
    bit issuer_en = 1'b0;

    // Behavioural reference state.
    int m_q[$];
    int m_t[$];
    bit m_busy = 1'b0;
    bit m_done = 1'b0;

    always #5 clk = ~clk;

    nand_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_vld_i(col_vld_i),
        .page_vld_i(page_vld_i), .large_page_i(large_page_i), .cap_sel_i(cap_sel_i),
        .page_addr_i(page_addr_i), .addr_done_i(addr_done_i),
        .addr_vld_o(addr_vld_o), .addr_byte_o(addr_byte_o), .addr_last_o(addr_last_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Reference model: advances on each clock edge from the requirements.
    always @(posedge clk) begin
        int nc, nr;
        cyc++;
        cmp_en = 1'b1;
        m_done = 1'b0;
        if (!rst_n) begin
            m_q.delete(); m_t.delete(); m_busy = 1'b0;
        end else if (!m_busy) begin
            if (start_i) begin
                nc = col_vld_i ? (large_page_i ? 2 : 1) : 0;
                nr = page_vld_i ? ((int'(cap_sel_i) >= (large_page_i ? 4 : 2)) ? 3 : 2) : 0;
                for (int i = 0; i < nc; i++) begin m_q.push_back(0); m_t.push_back(1); end
                for (int i = 0; i < nr; i++) begin
                    m_q.push_back(int'((page_addr_i >> (8*i)) & 24'hff)); m_t.push_back(2);
                end
                if (m_q.size() == 0) m_done = 1'b1;
                else                 m_busy = 1'b1;
            end
        end else if (addr_done_i) begin
            void'(m_q.pop_front()); void'(m_t.pop_front());
            if (m_q.size() == 0) begin m_busy = 1'b0; m_done = 1'b1; end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(addr_vld_o == m_busy, "R7", "addr_vld_o", addr_vld_o, m_busy);
            chk(busy_o == m_busy, "R9", "busy_o", busy_o, m_busy);
            chk(done_o == m_done, "R8", "done_o", done_o, m_done);
            if (m_busy && m_q.size() > 0) begin
                chk(addr_byte_o == m_q[0][7:0], (m_t[0] == 1) ? "R1" : "R2",
                    "addr_byte_o", addr_byte_o, m_q[0]);
                chk(addr_last_o == (m_q.size() == 1), "R5", "addr_last_o",
                    addr_last_o, int'(m_q.size() == 1));
            end
        end
    end

    // Random issuer; counts handshakes that the next edge will complete.
    always @(negedge clk) begin
        bit nd;
        nd = issuer_en && ($urandom_range(0, 2) != 0);
        addr_done_i = nd;
        if (addr_vld_o && nd) hs_cnt++;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, fail_cnt);
        $finish;
    end

    // Run one sequence and check its byte count; hold>0 keeps start high with
    // altered request inputs for that many extra cycles.
    task automatic run_seq(input bit cv, input bit pv, input bit lp, input logic [2:0] cap,
                           input logic [23:0] pa, input int exp_cnt, input int hold,
                           input string tag);
        int base, w;
        @(negedge clk); #1;
        col_vld_i = cv; page_vld_i = pv; large_page_i = lp; cap_sel_i = cap;
        page_addr_i = pa; start_i = 1'b1;
        base = hs_cnt;
        w = 0;
        forever begin
            @(negedge clk);
            if (done_o || w > 300) break;
            #1;
            if (w < hold) begin
                col_vld_i = ~cv; page_vld_i = 1'b1; large_page_i = ~lp;
                cap_sel_i = ~cap; page_addr_i = ~pa;
            end else start_i = 1'b0;
            w++;
        end
        #1; start_i = 1'b0;
        chk(done_o == 1'b1, tag, "done seen", done_o, 1);
        chk(hs_cnt - base == exp_cnt, tag, "byte count", hs_cnt - base, exp_cnt);
        if (exp_cnt == 0) chk(w == 0, "R6", "done latency", w, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state.
        chk(addr_vld_o == 1'b0, "R10", "addr_vld_o in reset", addr_vld_o, 0);
        chk(busy_o == 1'b0, "R10", "busy_o in reset", busy_o, 0);
        chk(done_o == 1'b0, "R10", "done_o in reset", done_o, 0);
        #1; rst_n = 1'b1;
        @(negedge clk); #1; issuer_en = 1'b1;
        repeat (4) @(negedge clk);   // R9: addr_done while idle, model compares

        run_seq(1, 1, 0, 3'd0, 24'h12_3456, 3, 0, "R4");   // small, 16 MiB
        run_seq(1, 1, 0, 3'd1, 24'hA1_B2C3, 3, 0, "R4");   // small, 32 MiB
        run_seq(1, 1, 0, 3'd2, 24'h65_4321, 4, 0, "R4");   // small, 64 MiB
        run_seq(1, 1, 1, 3'd3, 24'hFE_DCBA, 4, 0, "R3");   // large, 128 MiB
        run_seq(1, 1, 1, 3'd4, 24'h0F_1E2D, 5, 0, "R3");   // large, 256 MiB
        run_seq(1, 0, 1, 3'd7, 24'hFF_FFFF, 2, 0, "R5");   // column only, large
        run_seq(1, 0, 0, 3'd7, 24'hFF_FFFF, 1, 0, "R5");   // column only, small
        run_seq(0, 1, 0, 3'd7, 24'h9A_BCDE, 3, 0, "R2");   // page only
        run_seq(0, 0, 1, 3'd5, 24'h00_0000, 0, 0, "R6");   // nothing
        run_seq(1, 1, 0, 3'd2, 24'h3C_5A69, 4, 2, "R9");   // start held while busy
        run_seq(0, 0, 0, 3'd0, 24'h00_0000, 0, 0, "R6");

        for (int k = 0; k < 40; k++) begin
            bit cv, pv, lp;
            logic [2:0] cap;
            int e;
            cv = 1'($urandom); pv = 1'($urandom); lp = 1'($urandom);
            cap = 3'($urandom);
            e = (cv ? (lp ? 2 : 1) : 0) + (pv ? ((int'(cap) >= (lp ? 4 : 2)) ? 3 : 2) : 0);
            run_seq(cv, pv, lp, cap, 24'($urandom), e, (k % 5 == 0) ? 1 : 0, "R2");
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, fail_cnt);
        $finish;
    end
endmodule